// File: doc/BRIEF.md
# Constant On-Time Pulse Generator

This block drives the high-side switch request of a ripple-regulated buck converter. A comparator outside the block raises a one-bit flag whenever the sensed feedback has dropped below the smaller of the soft-start ramp and the regulation reference. While the generator is enabled and armed, that flag opens a PWM pulse. The pulse lasts a programmed number of clock cycles. Outside logic sets that count so that it falls as the input voltage rises, which keeps the switching frequency roughly constant.

When a pulse ends, the block enforces a programmed minimum low interval before another pulse may start. A trigger seen during a pulse or during that low interval is dropped and never queued. The switching frequency therefore follows the load but cannot exceed one pulse per on-time plus minimum off-time. Under a heavy load step the block reaches that ceiling by firing again on the first cycle the low interval allows. A pre-charged output produces no pulses until the feedback itself falls below target. A shutdown request or a low run enable forces the output low at once.

Top module: `coton_pulse_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `pwm_o` is low.
- R2: A pulse starts only from the armed condition. When `fb_low` is sampled high at a rising edge in that condition, `pwm_o` is high from that edge on.
- R3: Each pulse that is not cut short holds `pwm_o` high for exactly `ton_cnt` clock cycles.
- R4: A `ton_cnt` of zero produces a pulse of one clock cycle, so a pulse is never lost.
- R5: After every pulse that is not cut short, `pwm_o` stays low for at least `toff_cnt` cycles. A `toff_cnt` of zero is treated as one cycle.
- R6: If `fb_low` is held high, pulses repeat back to back. Each period is exactly the effective on count plus the effective off count.
- R7: A high `fb_low` during a pulse or inside the minimum low interval is not stored. If it is gone by the time the interval expires, no pulse follows.
- R8: While `fb_low` stays low, as it does with a pre-biased output above target, `pwm_o` never goes high.
- R9: A high `shutdown` sampled at an edge forces `pwm_o` low from that edge on. This aborts a running pulse, and no pulse starts while it stays high.
- R10: A low `run_en` forces `pwm_o` low and clears the interval counter. When `run_en` returns, the block is armed at once with no leftover low interval.
- R11: The on count is captured when a pulse starts and the off count when it ends. Changing `ton_cnt` during a pulse does not change that pulse's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; low holds the block idle |
| fb_low | input | 1 | Feedback below min(soft-start, reference) |
| ton_cnt | input | CNT_W | On-time length in clock cycles (0 means 1) |
| toff_cnt | input | CNT_W | Minimum off-time in clock cycles (0 means 1) |
| shutdown | input | 1 | Shutdown request, forces output low |
| pwm_o | output | 1 | High-side PWM request |

## Verification
Embedded properties check several rules on every cycle: a disabled or shut-down block drives the output low, every rising edge of the output follows a sampled trigger, each completed pulse has exactly the length captured at its start, and each new pulse follows a low stretch at least as long as the captured off count. The bench scenarios show the rest. These are the drop of a trigger that comes and goes inside the blocked window, back-to-back pulsing at the maximum rate, the clamping of zero counts to one cycle, and re-arming right after the enable returns. The bench also checks that a count changed in mid-pulse has no effect.

// File: rtl/coton_pkg.sv
package coton_pkg;

    // Sequencing phase of the pulse generator
    typedef enum logic [1:0] {
        PH_ARMED = 2'd0,
        PH_ON    = 2'd1,
        PH_OFF   = 2'd2
    } phase_e;

    // Command to the shared interval counter
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_CLEAR = 2'd2
    } cnt_cmd_e;

    // Qualified control inputs after enable gating
    typedef struct packed {
        logic enabled;
        logic start;
    } qual_s;

endpackage

// File: rtl/coton_interval_counter.sv
module coton_interval_counter
    import coton_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_cmd_e         cmd,
    input  logic [CNT_W-1:0] load_val,
    output logic             cnt_zero
);

    logic [CNT_W-1:0] remain_q;

    // Loadable down counter that parks at zero
    always_ff @(posedge clk) begin
        if (rst || cmd == CMD_CLEAR) begin
            remain_q <= '0;
        end else if (cmd == CMD_LOAD) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign cnt_zero = (remain_q == '0);

    // Counter must never wrap from zero upward without a load
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt_zero && cmd == CMD_HOLD) |=> cnt_zero);

endmodule

// File: rtl/coton_start_qualifier.sv
module coton_start_qualifier
    import coton_pkg::*;
(
    input  phase_e phase,
    input  logic   cnt_zero,
    input  logic   run_en,
    input  logic   shutdown,
    input  logic   fb_low,
    output qual_s  qual
);

    logic ready;

    // Armed, or in the last cycle of the off window
    always_comb begin
        ready        = (phase == PH_ARMED) || (phase == PH_OFF && cnt_zero);
        qual.enabled = run_en && !shutdown;
        qual.start   = qual.enabled && ready && fb_low;
    end

endmodule

// File: rtl/coton_pulse_gen.sv
module coton_pulse_gen
    import coton_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             fb_low,
    input  logic [CNT_W-1:0] ton_cnt,
    input  logic [CNT_W-1:0] toff_cnt,
    input  logic             shutdown,
    output logic             pwm_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_e           phase_q, phase_n;
    cnt_cmd_e         cmd;
    logic [CNT_W-1:0] load_val;
    logic             cnt_zero;
    qual_s            qual;
    logic [CNT_W-1:0] on_eff, off_eff;

    // Zero counts are clamped to one cycle
    assign on_eff  = (ton_cnt  == '0) ? ONE : ton_cnt;
    assign off_eff = (toff_cnt == '0) ? ONE : toff_cnt;

    coton_start_qualifier u_qual (
        .phase    (phase_q),
        .cnt_zero (cnt_zero),
        .run_en   (run_en),
        .shutdown (shutdown),
        .fb_low   (fb_low),
        .qual     (qual)
    );

    coton_interval_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_val (load_val),
        .cnt_zero (cnt_zero)
    );

    always_comb begin
        phase_n  = phase_q;
        cmd      = CMD_HOLD;
        load_val = '0;
        if (!qual.enabled) begin
            phase_n = PH_ARMED;
            cmd     = CMD_CLEAR;
        end else if (qual.start) begin
            phase_n  = PH_ON;
            cmd      = CMD_LOAD;
            load_val = on_eff - ONE;
        end else begin
            case (phase_q)
                PH_ON: if (cnt_zero) begin
                    phase_n  = PH_OFF;
                    cmd      = CMD_LOAD;
                    load_val = off_eff - ONE;
                end
                PH_OFF: if (cnt_zero) phase_n = PH_ARMED;
                default: phase_n = phase_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_ARMED;
        else     phase_q <= phase_n;
    end

    assign pwm_o = (phase_q == PH_ON);

    // ---------------- checking logic and properties ----------------
    logic [CNT_W:0]   ck_hi, ck_lo;
    logic [CNT_W-1:0] ck_on_req, ck_off_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_hi      <= '0;
            ck_lo      <= '0;
            ck_on_req  <= ONE;
            ck_off_req <= '0;
        end else begin
            ck_hi <= pwm_o ? ck_hi + 1'b1 : '0;
            if (pwm_o)            ck_lo <= '0;
            else if (ck_lo != '1) ck_lo <= ck_lo + 1'b1;
            if (qual.start) ck_on_req <= on_eff;
            if (!qual.enabled) ck_off_req <= '0;
            else if (cmd == CMD_LOAD && phase_n == PH_OFF) ck_off_req <= off_eff;
        end
    end

    p_reset_low_r1: assert property (@(posedge clk) rst |=> !pwm_o);

    p_rise_needs_fb_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_o) |-> $past(fb_low));

    p_on_width_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(pwm_o) && $past(qual.enabled)) |-> (ck_hi == {1'b0, ck_on_req}));

    p_min_off_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_o) |-> (ck_lo >= {1'b0, ck_off_req}));

    p_shutdown_low_r9: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> !pwm_o);

    p_run_low_r10: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> !pwm_o);

endmodule

// File: tb/coton_pulse_gen_tb.sv
module coton_pulse_gen_tb;
    localparam int W = 10;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst = 1'b1, run_en = 1'b1, fb_low = 1'b0, shutdown = 1'b0;
    logic [W-1:0] ton = 10'd3, toff = 10'd4;
    logic         pwm;
    int checks = 0, fails = 0;
    bit done = 0;

    coton_pulse_gen #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .run_en(run_en), .fb_low(fb_low),
        .ton_cnt(ton), .toff_cnt(toff), .shutdown(shutdown), .pwm_o(pwm)
    );

    // Reference model built from the requirements
    int m_mode = 0, m_left = 0;
    function automatic int effv(logic [W-1:0] v);
        return (v == '0) ? 1 : int'(v);
    endfunction

    always @(posedge clk) begin
        if (rst || !run_en || shutdown) begin
            m_mode <= 0; m_left <= 0;
        end else if ((m_mode == 0 || (m_mode == 2 && m_left == 1)) && fb_low) begin
            m_mode <= 1; m_left <= effv(ton);
        end else if (m_mode == 1) begin
            if (m_left == 1) begin m_mode <= 2; m_left <= effv(toff); end
            else m_left <= m_left - 1;
        end else if (m_mode == 2) begin
            if (m_left == 1) m_mode <= 0;
            else m_left <= m_left - 1;
        end
    end

    task automatic chk(logic exp, string tag);
        checks++;
        if (pwm !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, pwm, exp);
        end
    endtask

    task automatic chk_val(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic measure(logic lvl, output int n);
        n = 0;
        while (pwm === lvl && n < 200) begin n++; step(); end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        @(negedge clk);
        step(2);
        chk(1'b0, "R1 during reset");
        rst = 1'b0;
        step();
        chk(1'b0, "R1 after reset");

        for (int i = 0; i < 5; i++) begin step(); chk(1'b0, "R8 prebias no pulse"); end

        fb_low = 1'b1; step(); chk(1'b1, "R2 pulse start");
        fb_low = 1'b0; measure(1'b1, n); chk_val(n, 3, "R3 width");

        fb_low = 1'b1; step(2); fb_low = 1'b0;
        for (int i = 0; i < 8; i++) begin step(); chk(1'b0, "R7 trigger not queued"); end

        fb_low = 1'b1; step(); chk(1'b1, "R6 first pulse");
        measure(1'b1, n); chk_val(n, 3, "R6 high part");
        measure(1'b0, n); chk_val(n, 4, "R5 min off");
        measure(1'b1, n); chk_val(n, 3, "R6 back to back");
        fb_low = 1'b0; step(6);

        ton = 10'd0; fb_low = 1'b1; step(); fb_low = 1'b0;
        measure(1'b1, n); chk_val(n, 1, "R4 zero on count");
        step(6);

        ton = 10'd2; toff = 10'd0; fb_low = 1'b1; step();
        measure(1'b1, n); chk_val(n, 2, "R6 high at zero off");
        measure(1'b0, n); chk_val(n, 1, "R5 zero off count");
        fb_low = 1'b0; measure(1'b1, n); step(4);

        toff = 10'd4; fb_low = 1'b1; step(); ton = 10'd7; fb_low = 1'b0;
        measure(1'b1, n); chk_val(n, 2, "R11 count captured");
        step(6);

        ton = 10'd6; fb_low = 1'b1; step(2);
        chk(1'b1, "R9 pulse running");
        shutdown = 1'b1; step(); chk(1'b0, "R9 abort");
        for (int i = 0; i < 5; i++) begin step(); chk(1'b0, "R9 held off"); end
        shutdown = 1'b0; fb_low = 1'b0; step(2);

        fb_low = 1'b1; step(); chk(1'b1, "R10 pulse running");
        run_en = 1'b0; step(); chk(1'b0, "R10 run low");
        for (int i = 0; i < 3; i++) begin step(); chk(1'b0, "R10 stays low"); end
        run_en = 1'b1; step(); chk(1'b1, "R10 immediate rearm");
        fb_low = 1'b0; measure(1'b1, n); chk_val(n, 6, "R10 fresh pulse");
        step(8);

        for (int i = 0; i < 3000; i++) begin
            fb_low   = ($urandom % 4) != 0;
            shutdown = ($urandom % 64) == 0;
            run_en   = ($urandom % 50) != 0;
            if (($urandom % 8) == 0) ton  = W'($urandom % 6);
            if (($urandom % 8) == 0) toff = W'($urandom % 6);
            step();
            chk(m_mode == 1, "R6 R7 random model");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule